// File: doc/BRIEF.md
# Dual-Rate External Bus Clock Divider

This block turns the system clock into the clock for an external bus and a one-cycle update strobe that marks each rising edge of that clock. A 32-bit read/write register holds two 16-bit divide counts. The block takes one of them for each access, according to which chip-select region is active. A count of zero passes the system clock straight through. A nonzero count N gives a square wave that is high for floor(N/2)+1 system cycles and low for the same number. The lowest bit of the count therefore has no effect, and every divide ratio is even.

Per-region rate selection is on only when three things hold together: the extended chip-select configuration is enabled, the configuration field is 1 or 2, and the rate-select enable is set. When it is on, region 3 takes the upper count and every other region takes the lower count. When it is off, every access takes the lower count. A new count, from either a register write or a chip-select change, is taken only when a low phase finishes, so the current period always runs to its end.

Top module: `xbus_rate_gen`

## Requirements
- R1: `rate_wr_en` high at a clock edge writes the whole of `rate_wr_data` into the rate register. Bits 15:0 are the lower count and bits 31:16 the upper count. `rate_rd_data` returns the stored word from the following cycle on.
- R2: The upper count is used only when `cs_ext_en`=1, `cs_cfg` is 1 or 2, `cs_rate_sel`=1 and `cs_idx`=3. In every other case the lower count is used.
- R3: When the count in use is zero, `xbus_clk` follows the system clock and `xbus_upd` is high on every cycle.
- R4: When the count N in use is nonzero, `xbus_clk` is high for H=floor(N/2)+1 system cycles and then low for H cycles, so the period is 2H.
- R5: Counts N and N with bit 0 flipped produce identical waveforms (for example, 2 and 3 both give period 4).
- R6: In divide mode, `xbus_upd` is high for exactly one system cycle, the first cycle of each high phase.
- R7: A change of the count in use takes effect only at the end of a low phase, or at the next edge while bypassing. The period already in progress finishes with its old length.
- R8: After reset the register reads 0, the block is in bypass, and `xbus_upd` is high.
- R9: When the block leaves bypass, the first high phase and its strobe begin at the clock edge that samples the new nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr_en | input | 1 | Write enable for the rate register |
| rate_wr_data | input | 32 | Write data: upper count in bits 31:16, lower count in bits 15:0 |
| rate_rd_data | output | 32 | Current register contents |
| cs_ext_en | input | 1 | Extended chip-select configuration enabled |
| cs_cfg | input | 2 | Chip-select configuration field |
| cs_rate_sel | input | 1 | Per-region rate selection enabled |
| cs_idx | input | 2 | Index of the active chip-select region |
| xbus_clk | output | 1 | External bus clock |
| xbus_upd | output | 1 | One-cycle strobe at each external clock rising edge |

## Verification
The assertions assume that the chip-select inputs and the write port change only between system clock edges, and that `rst_n` is held low for at least one full clock edge. The bench drives every input on the falling edge and holds reset over several rising edges. The assertions also take the internal phase counter to be reloaded only at a phase end. For that reason the stimulus makes count and region changes at arbitrary points inside a period, including in the middle of a high phase, and checks that the running period is never cut short.

// File: rtl/xrg_pkg.sv
package xrg_pkg;

   localparam int unsigned NUM_FIELDS = 2;
   localparam int unsigned UPPER_REGION = 3;

   // Per-region rate selection needs all three configuration conditions.
   function automatic logic region_mode_on(input logic ext_en,
                                           input logic [1:0] cfg,
                                           input logic rate_sel);
      return ext_en && ((cfg == 2'd1) || (cfg == 2'd2)) && rate_sel;
   endfunction

endpackage

// File: rtl/xrg_regs.sv
module xrg_regs #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned NUM_F = 2,
   localparam int unsigned REG_W = CNT_W * NUM_F
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [REG_W-1:0]             wr_data,
   output logic [NUM_F-1:0][CNT_W-1:0]  fields,
   output logic [REG_W-1:0]             rd_data
);

   for (genvar f = 0; f < NUM_F; f++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fields[f] <= '0;
         else if (wr_en)
            fields[f] <= wr_data[f*CNT_W +: CNT_W];
      end
   end

   assign rd_data = fields;

   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == $past(wr_data)));  // R1

endmodule

// File: rtl/xrg_select.sv
module xrg_select #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned CS_W  = 2
) (
   input  logic [1:0][CNT_W-1:0] fields,
   input  logic                  ext_en,
   input  logic [1:0]            cfg,
   input  logic                  rate_sel,
   input  logic [CS_W-1:0]       cs_idx,
   output logic [CNT_W-1:0]      active_cnt
);
   import xrg_pkg::*;

   logic use_upper;

   always_comb begin
      use_upper  = region_mode_on(ext_en, cfg, rate_sel)
                   && (cs_idx == CS_W'(UPPER_REGION));
      active_cnt = use_upper ? fields[1] : fields[0];
   end

endmodule

// File: rtl/xrg_divider.sv
module xrg_divider #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] req_cnt,
   output logic             xclk,
   output logic             xclk_edge
);

   logic             byp_q;
   logic [CNT_W-1:0] half_q;
   logic [CNT_W-1:0] cnt_q;
   logic             xq;
   logic             rise_q;
   logic             req_byp;
   logic [CNT_W-1:0] req_half;
   logic             boundary;

   always_comb begin
      req_byp  = (req_cnt == '0);
      req_half = {1'b0, req_cnt[CNT_W-1:1]} + 1'b1;
      boundary = byp_q || (!xq && (cnt_q == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q  <= 1'b1;
         half_q <= CNT_W'(1);
         cnt_q  <= '0;
         xq     <= 1'b0;
         rise_q <= 1'b0;
      end else if (boundary) begin
         byp_q  <= req_byp;
         half_q <= req_half;
         xq     <= !req_byp;
         cnt_q  <= req_byp ? '0 : (req_half - 1'b1);
         rise_q <= !req_byp;
      end else begin
         rise_q <= 1'b0;
         if (cnt_q == '0) begin
            xq    <= 1'b0;
            cnt_q <= half_q - 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign xclk      = byp_q ? clk : xq;
   assign xclk_edge = byp_q | rise_q;

   // Checker state: cycles since the latest rising edge of the divided clock.
   logic [CNT_W:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_run <= '0;
      else if (boundary)
         hi_run <= '0;
      else
         hi_run <= hi_run + 1'b1;
   end

   AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (xq && (cnt_q == '0)) |-> (hi_run == {1'b0, half_q - 1'b1}));  // R4
   AST_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xq) |-> rise_q);  // R6
   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |=> !rise_q);  // R6
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ($stable(half_q) && $stable(byp_q)));  // R7

endmodule

// File: rtl/xbus_rate_gen.sv
module xbus_rate_gen #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned CS_W  = 2,
   localparam int unsigned REG_W = CNT_W * xrg_pkg::NUM_FIELDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rate_wr_en,
   input  logic [REG_W-1:0] rate_wr_data,
   output logic [REG_W-1:0] rate_rd_data,
   input  logic             cs_ext_en,
   input  logic [1:0]       cs_cfg,
   input  logic             cs_rate_sel,
   input  logic [CS_W-1:0]  cs_idx,
   output logic             xbus_clk,
   output logic             xbus_upd
);

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt_w
      $error("xbus_rate_gen: CNT_W must lie in 2..31");
   end
   if (CS_W < 2) begin : g_bad_cs_w
      $error("xbus_rate_gen: CS_W must be at least 2");
   end

   logic [1:0][CNT_W-1:0] fields;
   logic [CNT_W-1:0]      active_cnt;

   xrg_regs #(.CNT_W(CNT_W), .NUM_F(xrg_pkg::NUM_FIELDS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rate_wr_en),
      .wr_data (rate_wr_data),
      .fields  (fields),
      .rd_data (rate_rd_data)
   );

   xrg_select #(.CNT_W(CNT_W), .CS_W(CS_W)) u_select (
      .fields     (fields),
      .ext_en     (cs_ext_en),
      .cfg        (cs_cfg),
      .rate_sel   (cs_rate_sel),
      .cs_idx     (cs_idx),
      .active_cnt (active_cnt)
   );

   xrg_divider #(.CNT_W(CNT_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_cnt   (active_cnt),
      .xclk      (xbus_clk),
      .xclk_edge (xbus_upd)
   );

endmodule

// File: tb/xbus_rate_gen_tb.sv
module xbus_rate_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_wr_en = 1'b0;
   logic [31:0] rate_wr_data = '0;
   logic [31:0] rate_rd_data;
   logic        cs_ext_en = 1'b0;
   logic [1:0]  cs_cfg = 2'd0;
   logic        cs_rate_sel = 1'b0;
   logic [1:0]  cs_idx = 2'd0;
   logic        xbus_clk;
   logic        xbus_upd;

   always #5 clk = ~clk;

   xbus_rate_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rate_wr_en   (rate_wr_en),
      .rate_wr_data (rate_wr_data),
      .rate_rd_data (rate_rd_data),
      .cs_ext_en    (cs_ext_en),
      .cs_cfg       (cs_cfg),
      .cs_rate_sel  (cs_rate_sel),
      .cs_idx       (cs_idx),
      .xbus_clk     (xbus_clk),
      .xbus_upd     (xbus_upd)
   );

   int  vectors = 0;
   int  errs = 0;
   bit  run_cmp = 1'b0;
   bit  done = 1'b0;

   // Behavioural reference: position inside the current output period.
   logic [15:0] m_lo = '0;
   logic [15:0] m_hi = '0;
   bit          m_byp = 1'b1;
   int          m_half = 1;
   int          m_pos = 0;
   int          m_n;

   function automatic int pick_count();
      bit region;
      region = cs_ext_en && (cs_cfg == 2'd1 || cs_cfg == 2'd2) && cs_rate_sel;
      return (region && cs_idx == 2'd3) ? int'(m_hi) : int'(m_lo);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lo = '0; m_hi = '0; m_byp = 1'b1; m_half = 1; m_pos = 0;
      end else begin
         if (m_byp || m_pos == 2*m_half - 1) begin
            m_n = pick_count();
            m_pos = 0;
            if (m_n == 0) m_byp = 1'b1;
            else begin m_byp = 1'b0; m_half = m_n/2 + 1; end
         end else begin
            m_pos++;
         end
         if (rate_wr_en) {m_hi, m_lo} = rate_wr_data;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (run_cmp && !done) begin
         chk("R4", "xbus_clk", xbus_clk, m_byp ? 0 : (m_pos < m_half));
         chk("R6", "xbus_upd", xbus_upd, (m_byp || m_pos == 0));
         chk("R1", "readback", rate_rd_data, {m_hi, m_lo});
      end
   end

   task automatic write_reg(input logic [31:0] v);
      @(negedge clk);
      rate_wr_en = 1'b1; rate_wr_data = v;
      @(negedge clk);
      rate_wr_en = 1'b0;
   endtask

   task automatic set_cs(input bit e, input logic [1:0] c, input bit s, input logic [1:0] i);
      @(negedge clk);
      cs_ext_en = e; cs_cfg = c; cs_rate_sel = s; cs_idx = i;
   endtask

   task automatic wait_strobe();
      @(negedge clk); #1;
      while (!xbus_upd) begin @(negedge clk); #1; end
   endtask

   task automatic measure(input int exp, input string req);
      int n;
      wait_strobe();
      n = 0;
      do begin @(negedge clk); #1; n++; end while (!xbus_upd && n < 70000);
      chk(req, "period", n, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   endtask

   initial begin
      #(190000 * 10);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      #1;
      chk("R8", "strobe in reset", xbus_upd, 1);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R8", "readback after reset", rate_rd_data, 0);
      chk("R8", "bypass strobe", xbus_upd, 1);
      run_cmp = 1'b1;

      // R3: bypass period
      measure(1, "R3");
      // R9, R4: divide counts
      write_reg(32'h0000_0001); measure(2, "R4");
      write_reg(32'h0000_0000); measure(1, "R3");
      write_reg(32'h0000_0002); measure(4, "R4");
      write_reg(32'h0000_0003); measure(4, "R5");
      write_reg(32'h0000_0004); measure(6, "R4");
      write_reg(32'h0000_0005); measure(6, "R5");
      @(negedge clk); #1;
      chk("R1", "readback", rate_rd_data, 32'h0000_0005);

      // R2: field selection across configurations
      write_reg({16'd8, 16'd2});
      set_cs(1, 2'd1, 1, 2'd3); measure(10, "R2");
      set_cs(1, 2'd1, 1, 2'd2); measure(4, "R2");
      set_cs(1, 2'd2, 1, 2'd3); measure(10, "R2");
      set_cs(1, 2'd0, 1, 2'd3); measure(4, "R2");
      set_cs(1, 2'd3, 1, 2'd3); measure(4, "R2");
      set_cs(0, 2'd1, 1, 2'd3); measure(4, "R2");
      set_cs(1, 2'd2, 0, 2'd3); measure(4, "R2");
      set_cs(1, 2'd2, 1, 2'd0); measure(4, "R2");
      set_cs(1, 2'd2, 1, 2'd3); measure(10, "R2");
      set_cs(0, 2'd0, 0, 2'd0);

      // R7: change in mid period keeps running period length
      write_reg(32'h0000_0004); measure(6, "R4");
      wait_strobe();
      @(negedge clk);
      rate_wr_en = 1'b1; rate_wr_data = 32'h0000_0010;
      #1; n = 1;
      @(negedge clk);
      rate_wr_en = 1'b0;
      #1; n = 2;
      while (!xbus_upd && n < 100) begin @(negedge clk); #1; n++; end
      chk("R7", "period across write", n, 6);
      measure(18, "R7");

      // R4: largest count, run last
      write_reg(32'h0000_FFFF); measure(65536, "R4");
      finish_run();
   end

endmodule